// File: doc/BRIEF.md
# Misaligned-Splitting Load-Store Unit

This unit sits between the execute stage and a 32-bit data bus. It accepts a single load or store request, which gives a byte address, a size and a signed flag. It turns that request into one aligned bus transaction, or into two when the access straddles a word boundary. For stores it builds the byte enables and positions the write data. For loads it merges the returned bytes and zero- or sign-extends them. When the access finishes, it gives the execute stage one completion pulse carrying the load result, any fault, and the original unaligned address for the exception value.

The bus follows a request/grant/response-valid/error handshake. The unit allows at most one transaction in flight. The outgoing request comes only from registered state and from the single permission bit. It never depends on the response-valid or error inputs. The permission check itself is done outside the unit. When the permission bit rejects a transaction, no bus request is made. The unit still steps through that transaction as if it had been granted, and the fault appears at the completion pulse. A split access always issues both halves, even when the first half fails.

Top module: `lsu_unit`

## Requirements
- R1: Once `data_req_o` is raised, it stays high, with address, byte enables and write data unchanged, until the cycle in which `data_gnt_i` is high. `data_req_o` is never high in a cycle where `data_rvalid_i` is high.
- R2: Byte enables use the size encoding 0 = byte (mask 0001), 1 = halfword (0011) and 2 = word (1111). The mask is shifted left by address bits [1:0]. Mask bits 3:0 go to the transaction at the aligned word address. Bits 7:4 go to the transaction at the next word (+4). Store data is shifted left by 8 times the offset, in the same split. Only enabled bytes are written.
- R3: A word access with a nonzero offset, or a halfword access at offset 3, makes exactly two bus transactions. Every other access makes exactly one.
- R4: Load data starts at the addressed byte and takes bytes from the first and second words in ascending address order. Bytes and halfwords are sign-extended when `lsu_signed_i` is 1 and zero-extended otherwise.
- R5: If the first half of a split access gets an error response, the second half is still issued on the bus. The access then completes with a fault.
- R6: If `perm_err_i` is high while a transaction is being requested, `data_req_o` stays low. The unit moves on without waiting for a grant or a response, and it reports a fault when the access completes.
- R7: A failing load raises `load_fault_o` and a failing store raises `store_fault_o`, each only together with `lsu_done_o`. `fault_addr_o` then holds the original request address.
- R8: With a zero-wait bus that responds one cycle after the grant, `lsu_done_o` is high 2 clock edges after the accepting edge for a single access and 4 for a split one. Each cycle the grant is held back adds one edge. `lsu_ready_o` is low while an access is in progress.
- R9: After reset, `lsu_ready_o` is 1, and `data_req_o`, `lsu_done_o`, `load_fault_o` and `store_fault_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lsu_req_i | input | 1 | Access request, taken while ready |
| lsu_we_i | input | 1 | 1 = store, 0 = load |
| lsu_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| lsu_signed_i | input | 1 | Sign-extend load result |
| lsu_addr_i | input | 32 | Byte address |
| lsu_wdata_i | input | 32 | Store data, right-aligned |
| lsu_ready_o | output | 1 | Idle, can accept a request |
| lsu_done_o | output | 1 | One-cycle completion pulse |
| lsu_rdata_o | output | 32 | Extended load result |
| load_fault_o | output | 1 | Load failed (with done) |
| store_fault_o | output | 1 | Store failed (with done) |
| fault_addr_o | output | 32 | Address of the failing access |
| data_req_o | output | 1 | Bus request |
| data_gnt_i | input | 1 | Bus grant |
| data_addr_o | output | 32 | Word-aligned bus address |
| data_we_o | output | 1 | Bus write |
| data_be_o | output | 4 | Bus byte enables |
| data_wdata_o | output | 32 | Bus write data |
| data_rvalid_i | input | 1 | Bus response valid |
| data_err_i | input | 1 | Bus response error |
| data_rdata_i | input | 32 | Bus read data |
| perm_err_i | input | 1 | Permission check failed for current bus address |

## Verification
The completion pulse is due 2 edges after the accepting edge for one transaction and 4 for two. Each grant wait cycle adds one edge, and a permission-rejected transaction takes the same time as a granted one. The bench counts the edges from the accepting edge until it sees `lsu_done_o` at a falling edge. It compares that count with the expected value, and it reads the result, fault flags and fault address in that same sample. It counts grants between operations to check one-versus-two transaction splitting. A per-edge monitor checks that requests are held stable and never overlap a response.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } lsu_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } lsu_state_e;
endpackage

// File: rtl/lsu_be_gen.sv
module lsu_be_gen
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  lsu_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              phase_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              split_o,
  output logic [BYTES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [BYTES-1:0]    mask;
  logic [2*BYTES-1:0]  be_wide;
  logic [2*DATA_W-1:0] wd_wide;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: mask = BYTES'(1);
      SZ_HALF: mask = BYTES'(3);
      default: mask = '1;
    endcase
  end

  assign be_wide = {{BYTES{1'b0}}, mask} << off_i;
  assign wd_wide = {{DATA_W{1'b0}}, wdata_i} << {off_i, 3'b000};

  // enables spilling past the word mark force a second transaction
  assign split_o = |be_wide[2*BYTES-1:BYTES];
  assign be_o    = phase_i ? be_wide[2*BYTES-1:BYTES] : be_wide[BYTES-1:0];
  assign wdata_o = phase_i ? wd_wide[2*DATA_W-1:DATA_W] : wd_wide[DATA_W-1:0];
endmodule

// File: rtl/lsu_rdata_align.sv
module lsu_rdata_align
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [OFF_W-1:0]  off_i,
  input  lsu_size_e         size_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] data_o
);
  logic [2*DATA_W-1:0] wide;
  logic [DATA_W-1:0]   raw;

  assign wide = {hi_i, lo_i} >> {off_i, 3'b000};
  assign raw  = wide[DATA_W-1:0];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(DATA_W-8){signed_i & raw[7]}}, raw[7:0]};
      SZ_HALF: data_o = {{(DATA_W-16){signed_i & raw[15]}}, raw[15:0]};
      default: data_o = raw;
    endcase
  end
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic split_i,
  input  logic gnt_i,
  input  logic perm_err_i,
  input  logic rvalid_i,
  input  logic err_i,
  output logic ready_o,
  output logic accept_o,
  output logic bus_req_o,
  output logic phase_o,
  output logic lo_capture_o,
  output logic finish_o,
  output logic fault_o
);
  lsu_state_e state_q, state_d;
  logic phase_q, phase_d;
  logic pmp_q, pmp_d;
  logic err_q, err_d;
  logic issue, adv, resp, last;

  assign issue    = (state_q == ST_REQ);
  assign adv      = issue && (gnt_i || perm_err_i);
  // a permission-rejected transaction never sees a response; complete it locally
  assign resp     = (state_q == ST_WAIT) && (rvalid_i || pmp_q);
  assign last     = !split_i || phase_q;
  assign accept_o = (state_q == ST_IDLE) && req_i;

  assign ready_o      = (state_q == ST_IDLE);
  assign bus_req_o    = issue && !perm_err_i;
  assign phase_o      = phase_q;
  assign finish_o     = resp && last;
  assign lo_capture_o = resp && !last;
  assign fault_o      = err_q || pmp_q || (rvalid_i && err_i);

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    pmp_d   = pmp_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d = ST_REQ;
        phase_d = 1'b0;
        pmp_d   = 1'b0;
        err_d   = 1'b0;
      end
      ST_REQ: if (adv) begin
        state_d = ST_WAIT;
        pmp_d   = perm_err_i;
      end
      ST_WAIT: if (resp) begin
        err_d = fault_o;
        if (last) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_REQ;
          phase_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      pmp_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      pmp_q   <= pmp_d;
      err_q   <= err_d;
    end
  end

  a_r5_second_after_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !phase_q && split_i && rvalid_i && err_i)
      |=> (state_q == ST_REQ && phase_q));

  a_r6_perm_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ && perm_err_i) |=> (state_q == ST_WAIT && pmp_q));

  a_r6_perm_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && pmp_q) |=> (state_q != ST_WAIT));
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lsu_req_i,
  input  logic              lsu_we_i,
  input  logic [1:0]        lsu_size_i,
  input  logic              lsu_signed_i,
  input  logic [ADDR_W-1:0] lsu_addr_i,
  input  logic [DATA_W-1:0] lsu_wdata_i,
  output logic              lsu_ready_o,
  output logic              lsu_done_o,
  output logic [DATA_W-1:0] lsu_rdata_o,
  output logic              load_fault_o,
  output logic              store_fault_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic              data_req_o,
  input  logic              data_gnt_i,
  output logic [ADDR_W-1:0] data_addr_o,
  output logic              data_we_o,
  output logic [BYTES-1:0]  data_be_o,
  output logic [DATA_W-1:0] data_wdata_o,
  input  logic              data_rvalid_i,
  input  logic              data_err_i,
  input  logic [DATA_W-1:0] data_rdata_i,
  input  logic              perm_err_i
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, lo_q;
  lsu_size_e         size_q;
  logic              we_q, signed_q;

  logic accept, phase, lo_capture, finish, fault, split;
  logic [DATA_W-1:0] align_lo, align_hi, load_data;
  logic [ADDR_W-OFF_W-1:0] word_addr;

  lsu_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (lsu_req_i),
    .split_i     (split),
    .gnt_i       (data_gnt_i),
    .perm_err_i  (perm_err_i),
    .rvalid_i    (data_rvalid_i),
    .err_i       (data_err_i),
    .ready_o     (lsu_ready_o),
    .accept_o    (accept),
    .bus_req_o   (data_req_o),
    .phase_o     (phase),
    .lo_capture_o(lo_capture),
    .finish_o    (finish),
    .fault_o     (fault)
  );

  lsu_be_gen #(.DATA_W(DATA_W)) u_be_gen (
    .size_i (size_q),
    .off_i  (addr_q[OFF_W-1:0]),
    .phase_i(phase),
    .wdata_i(wdata_q),
    .split_o(split),
    .be_o   (data_be_o),
    .wdata_o(data_wdata_o)
  );

  assign align_lo = split ? lo_q : data_rdata_i;
  assign align_hi = split ? data_rdata_i : '0;

  lsu_rdata_align #(.DATA_W(DATA_W)) u_align (
    .lo_i    (align_lo),
    .hi_i    (align_hi),
    .off_i   (addr_q[OFF_W-1:0]),
    .size_i  (size_q),
    .signed_i(signed_q),
    .data_o  (load_data)
  );

  assign word_addr   = addr_q[ADDR_W-1:OFF_W] + (ADDR_W-OFF_W)'(phase);
  assign data_addr_o = {word_addr, {OFF_W{1'b0}}};
  assign data_we_o   = we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      size_q   <= SZ_BYTE;
      we_q     <= 1'b0;
      signed_q <= 1'b0;
      lo_q     <= '0;
    end else begin
      if (accept) begin
        addr_q   <= lsu_addr_i;
        wdata_q  <= lsu_wdata_i;
        size_q   <= lsu_size_e'(lsu_size_i);
        we_q     <= lsu_we_i;
        signed_q <= lsu_signed_i;
      end
      if (lo_capture) lo_q <= data_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsu_done_o    <= 1'b0;
      lsu_rdata_o   <= '0;
      load_fault_o  <= 1'b0;
      store_fault_o <= 1'b0;
      fault_addr_o  <= '0;
    end else begin
      lsu_done_o    <= finish;
      load_fault_o  <= finish && fault && !we_q;
      store_fault_o <= finish && fault && we_q;
      if (finish) begin
        lsu_rdata_o  <= load_data;
        fault_addr_o <= addr_q;
      end
    end
  end

  a_r1_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_req_o && !data_gnt_i) |=> (data_req_o && $stable(data_addr_o)
      && $stable(data_be_o) && $stable(data_wdata_o)));

  a_r1_no_req_on_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rvalid_i |-> !data_req_o);

  a_r2_be_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_req_o |-> (data_be_o != '0));

  a_r7_fault_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_fault_o || store_fault_o) |-> (lsu_done_o && !(load_fault_o && store_fault_o)));

  a_r8_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsu_done_o |-> lsu_ready_o);
endmodule

// File: tb/lsu_unit_test.sv
`timescale 1ns/1ps
module lsu_unit_test;
  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic        sg;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        flt;
    logic [3:0]  lat;
    logic [1:0]  txn;
  } vec_t;

  localparam int NV = 25;
  // byte at address k starts as 8'h70 + k; word 14 is permission-rejected, word 15 bus-errors
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 1'b0, 32'd4,  32'h0,        32'h77767574, 1'b0, 4'd2, 2'd1},
    '{1'b0, 2'd0, 1'b0, 32'd2,  32'h0,        32'h00000072, 1'b0, 4'd2, 2'd1},
    '{1'b0, 2'd0, 1'b1, 32'd17, 32'h0,        32'hFFFFFF81, 1'b0, 4'd2, 2'd1},
    '{1'b0, 2'd0, 1'b0, 32'd17, 32'h0,        32'h00000081, 1'b0, 4'd2, 2'd1},
    '{1'b0, 2'd1, 1'b1, 32'd18, 32'h0,        32'hFFFF8382, 1'b0, 4'd2, 2'd1},
    '{1'b0, 2'd1, 1'b0, 32'd7,  32'h0,        32'h00007877, 1'b0, 4'd4, 2'd2},
    '{1'b0, 2'd2, 1'b0, 32'd5,  32'h0,        32'h78777675, 1'b0, 4'd4, 2'd2},
    '{1'b0, 2'd2, 1'b0, 32'd22, 32'h0,        32'h89888786, 1'b0, 4'd4, 2'd2},
    '{1'b0, 2'd1, 1'b1, 32'd19, 32'h0,        32'hFFFF8483, 1'b0, 4'd4, 2'd2},
    '{1'b0, 2'd1, 1'b1, 32'd2,  32'h0,        32'h00007372, 1'b0, 4'd2, 2'd1},
    '{1'b0, 2'd0, 1'b1, 32'd3,  32'h0,        32'h00000073, 1'b0, 4'd2, 2'd1},
    '{1'b1, 2'd2, 1'b0, 32'd9,  32'hDDCCBBAA, 32'h0,        1'b0, 4'd4, 2'd2},
    '{1'b0, 2'd2, 1'b0, 32'd8,  32'h0,        32'hCCBBAA78, 1'b0, 4'd2, 2'd1},
    '{1'b0, 2'd2, 1'b0, 32'd12, 32'h0,        32'h7F7E7DDD, 1'b0, 4'd2, 2'd1},
    '{1'b1, 2'd0, 1'b0, 32'd26, 32'h000000EE, 32'h0,        1'b0, 4'd2, 2'd1},
    '{1'b1, 2'd1, 1'b0, 32'd27, 32'h00001234, 32'h0,        1'b0, 4'd4, 2'd2},
    '{1'b0, 2'd2, 1'b0, 32'd24, 32'h0,        32'h34EE8988, 1'b0, 4'd2, 2'd1},
    '{1'b0, 2'd0, 1'b0, 32'd28, 32'h0,        32'h00000012, 1'b0, 4'd2, 2'd1},
    '{1'b0, 2'd2, 1'b0, 32'd60, 32'h0,        32'h0,        1'b1, 4'd2, 2'd1},
    '{1'b0, 2'd2, 1'b0, 32'd58, 32'h0,        32'h0,        1'b1, 4'd4, 2'd1},
    '{1'b0, 2'd1, 1'b0, 32'd55, 32'h0,        32'h0,        1'b1, 4'd4, 2'd1},
    '{1'b1, 2'd2, 1'b0, 32'd62, 32'h55667788, 32'h0,        1'b1, 4'd4, 2'd2},
    '{1'b0, 2'd1, 1'b0, 32'd0,  32'h0,        32'h00005566, 1'b0, 4'd2, 2'd1},
    '{1'b1, 2'd0, 1'b0, 32'd57, 32'h000000AB, 32'h0,        1'b1, 4'd2, 2'd0},
    '{1'b0, 2'd1, 1'b1, 32'd30, 32'h0,        32'hFFFF8F8E, 1'b0, 4'd2, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        lsu_req = 1'b0, lsu_we = 1'b0, lsu_signed = 1'b0;
  logic [1:0]  lsu_size = 2'd0;
  logic [31:0] lsu_addr = '0, lsu_wdata = '0;
  logic        lsu_ready, lsu_done, load_fault, store_fault;
  logic [31:0] lsu_rdata, fault_addr;
  logic        data_req, data_gnt, data_we, data_rvalid, data_err, perm_err;
  logic [31:0] data_addr, data_wdata, data_rdata;
  logic [3:0]  data_be;

  lsu_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lsu_req_i(lsu_req), .lsu_we_i(lsu_we), .lsu_size_i(lsu_size),
    .lsu_signed_i(lsu_signed), .lsu_addr_i(lsu_addr), .lsu_wdata_i(lsu_wdata),
    .lsu_ready_o(lsu_ready), .lsu_done_o(lsu_done), .lsu_rdata_o(lsu_rdata),
    .load_fault_o(load_fault), .store_fault_o(store_fault), .fault_addr_o(fault_addr),
    .data_req_o(data_req), .data_gnt_i(data_gnt), .data_addr_o(data_addr),
    .data_we_o(data_we), .data_be_o(data_be), .data_wdata_o(data_wdata),
    .data_rvalid_i(data_rvalid), .data_err_i(data_err), .data_rdata_i(data_rdata),
    .perm_err_i(perm_err)
  );

  // bus model
  logic [7:0]  mem_b [64];
  logic [3:0]  wcnt = '0;
  logic [3:0]  wait_n = '0;
  int          txn_cnt = 0;
  logic [3:0]  last_be = '0, prev_be = '0;
  int          viol = 0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0, pend_wd = '0;
  logic [3:0]  pend_be = '0;

  assign perm_err = (data_addr[5:2] == 4'd14);
  assign data_gnt = data_req && (wcnt >= wait_n);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 64; k++) mem_b[k] <= 8'h70 + 8'(k);
      data_rvalid <= 1'b0;
      data_err    <= 1'b0;
      data_rdata  <= '0;
      wcnt        <= '0;
    end else begin
      wcnt        <= (data_req && !data_gnt) ? wcnt + 4'd1 : 4'd0;
      data_rvalid <= data_req && data_gnt;
      if (data_req && data_gnt) begin
        txn_cnt    <= txn_cnt + 1;
        prev_be    <= last_be;
        last_be    <= data_be;
        data_err   <= (data_addr[5:2] == 4'd15);
        data_rdata <= {mem_b[{data_addr[5:2], 2'd3}], mem_b[{data_addr[5:2], 2'd2}],
                       mem_b[{data_addr[5:2], 2'd1}], mem_b[{data_addr[5:2], 2'd0}]};
        if (data_we && data_addr[5:2] != 4'd15)
          for (int b = 0; b < 4; b++)
            if (data_be[b]) mem_b[{data_addr[5:2], 2'(b)}] <= data_wdata[8*b +: 8];
      end
    end
  end

  // R1 monitor: held request and no overlap with a response
  always @(posedge clk) begin
    if (rst_n) begin
      if (pend && !(data_req && data_addr == pend_addr && data_be == pend_be
                    && data_wdata == pend_wd)) viol <= viol + 1;
      if (data_rvalid && data_req) viol <= viol + 1;
    end
    pend      <= rst_n && data_req && !data_gnt;
    pend_addr <= data_addr;
    pend_be   <= data_be;
    pend_wd   <= data_wdata;
  end

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  int          op_lat, op_txn;
  logic        op_busy_ready;
  logic [31:0] op_rdata, op_faddr;
  logic        op_lf, op_sf;

  task automatic run_op(input logic we, input logic [1:0] sz, input logic sg,
                        input logic [31:0] a, input logic [31:0] wd);
    int t0;
    @(negedge clk);
    while (!lsu_ready) @(negedge clk);
    lsu_we = we; lsu_size = sz; lsu_signed = sg; lsu_addr = a; lsu_wdata = wd;
    lsu_req = 1'b1;
    t0 = txn_cnt;
    @(posedge clk);
    #1 lsu_req = 1'b0;
    op_lat = 0;
    op_busy_ready = 1'b1;
    for (int n = 0; n < 40; n++) begin
      @(posedge clk);
      op_lat++;
      @(negedge clk);
      if (op_lat == 1) op_busy_ready = lsu_ready;
      if (lsu_done) break;
    end
    op_rdata = lsu_rdata; op_lf = load_fault; op_sf = store_fault; op_faddr = fault_addr;
    op_txn = txn_cnt - t0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 ready", 32'(lsu_ready), 32'd1);
    chk("R9 req", 32'(data_req), 32'd0);
    chk("R9 done", 32'(lsu_done), 32'd0);
    chk("R9 faults", {30'd0, load_fault, store_fault}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].we, VECS[i].sz, VECS[i].sg, VECS[i].addr, VECS[i].wd);
      chk($sformatf("R8 vec%0d latency", i), 32'(op_lat), 32'(VECS[i].lat));
      chk($sformatf("R3 vec%0d transactions", i), 32'(op_txn), 32'(VECS[i].txn));
      if (!VECS[i].we && !VECS[i].flt)
        chk($sformatf("R4 vec%0d rdata", i), op_rdata, VECS[i].exp);
      // vec19/20/23 exercise R6, vec19/21 exercise R5
      chk($sformatf("R7 vec%0d load fault", i), 32'(op_lf), 32'(VECS[i].flt && !VECS[i].we));
      chk($sformatf("R7 vec%0d store fault", i), 32'(op_sf), 32'(VECS[i].flt && VECS[i].we));
      if (VECS[i].flt)
        chk($sformatf("R7 vec%0d fault addr", i), op_faddr, VECS[i].addr);
    end

    // R5 split store after error on first half: second half wrote bytes 0,1 (checked by vec22 too)
    run_op(1'b1, 2'd2, 1'b0, 32'd62, 32'hA1B2C3D4);
    chk("R5 second half issued", 32'(op_txn), 32'd2);
    chk("R5 store fault", 32'(op_sf), 32'd1);
    run_op(1'b0, 2'd1, 1'b0, 32'd0, 32'h0);
    chk("R5 second half data", op_rdata, 32'h0000A1B2);

    // R6 permission-rejected store leaves no bus activity
    run_op(1'b1, 2'd2, 1'b0, 32'd56, 32'hFFFFFFFF);
    chk("R6 no transaction", 32'(op_txn), 32'd0);
    chk("R6 fault", 32'(op_sf), 32'd1);

    // R2 byte enables for halfword at offset 3
    run_op(1'b1, 2'd1, 1'b0, 32'd27, 32'h00001234);
    chk("R2 first be", 32'(prev_be), 32'h8);
    chk("R2 second be", 32'(last_be), 32'h1);
    run_op(1'b1, 2'd0, 1'b0, 32'd33, 32'h000000C5);
    chk("R2 byte be", 32'(last_be), 32'h2);
    run_op(1'b0, 2'd2, 1'b0, 32'd32, 32'h0);
    chk("R2 only enabled byte written", op_rdata, 32'h9392C590);

    // R8 grant wait states stretch each half; R1 held request
    wait_n = 4'd2;
    run_op(1'b0, 2'd2, 1'b0, 32'd5, 32'h0);
    chk("R8 latency with waits", 32'(op_lat), 32'd8);
    chk("R8 busy not ready", 32'(op_busy_ready), 32'd0);
    chk("R4 data with waits", op_rdata, 32'h78777675);
    wait_n = 4'd0;
    repeat (2) @(negedge clk);
    chk("R1 protocol violations", 32'(viol), 32'd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R8 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule